// File: doc/BRIEF.md
# Fine-Grain Thread Select Unit

This block chooses which of four hardware threads issues an instruction in each clock cycle of a single-issue, in-order pipeline. It sits in its own stage between fetch and decode. Each thread owns a small instruction FIFO that fetch fills through a valid/ready write port. Each cycle the block picks one thread whose FIFO holds an instruction and that no stall source holds. It pops that thread's FIFO and registers the thread index and the instruction word for the muxes in front of decode.

The pick rotates round-robin and moves to a different thread every cycle when more than one is eligible. A thread is skipped while any of its stall inputs is high. The stall inputs are an outstanding cache miss, a pending trap or interrupt, a resource conflict, and a long-latency operation in flight. A per-thread flush empties that thread's FIFO.

Top module: `tsel_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every FIFO, so `fetchReady` reads 4'b1111 and `issueValid` is 0. It also sets the rotation pointer to thread 0, so the first issue after reset with all threads eligible goes to thread 0.
- R2: Among eligible threads the pick is the first one found searching upward, with wrap-around, from the rotation pointer. Thread index bit i of every per-thread vector belongs to thread i.
- R3: A thread is eligible only when its FIFO is non-empty, none of `missStall`, `trapStall`, `conflictStall`, `longOpStall` is high for it, and `flush` is low for it. Stalled and empty threads are skipped.
- R4: When no thread is eligible, `issueValid` is 0 in the following cycle and no FIFO is popped.
- R5: After an issue from thread t, the rotation pointer becomes (t+1) mod 4. In a cycle with no issue it keeps its value.
- R6: Each FIFO holds 4 entries and delivers them in write order. `fetchReady[t]` is 0 while FIFO t is full, and a write offered then is dropped.
- R7: A FIFO accepts a write and is popped in the same cycle.
- R8: `flush[t]` empties FIFO t at the next edge and overrides a write to that FIFO in the same cycle.
- R9: `issueValid`, `issueTid` and `issueInstr` are registers. They show the pick made from the inputs present before a clock edge, and they do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchValid | input | 4 | Per-thread write strobe from fetch |
| fetchData | input | 4x32 | Per-thread instruction word from fetch |
| fetchReady | output | 4 | Per-thread FIFO not full |
| flush | input | 4 | Per-thread FIFO clear |
| missStall | input | 4 | Per-thread outstanding cache miss |
| trapStall | input | 4 | Per-thread pending trap or interrupt |
| conflictStall | input | 4 | Per-thread resource conflict |
| longOpStall | input | 4 | Per-thread long-latency operation in flight |
| issueValid | output | 1 | An instruction is issued this cycle |
| issueTid | output | 2 | Thread index steering the decode muxes |
| issueInstr | output | 32 | Issued instruction word |

## Verification
The assertions assume a clean reset at the start and treat stall and flush inputs as levels sampled at the clock. They also assume fetch only counts a write as accepted when `fetchReady` is high; a write offered while the FIFO is full is simply lost. The bench changes every input half a cycle away from the active edge. It holds all threads stalled while it fills the FIFOs. It then drives stall masks from a table, so each stall source, the empty-FIFO skip and the all-blocked case are met with the FIFO contents known in advance.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int THREADS = 4;
  localparam int TID_W   = $clog2(THREADS);

  // Strobes from the control to the datapath: one pop for the chosen thread.
  typedef struct packed {
    logic             issue;
    logic [TID_W-1:0] tid;
  } selStrobe_t;
endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [THREADS-1:0] bufNotEmpty,
  input  logic [THREADS-1:0] flush,
  input  logic [THREADS-1:0] missStall,
  input  logic [THREADS-1:0] trapStall,
  input  logic [THREADS-1:0] conflictStall,
  input  logic [THREADS-1:0] longOpStall,
  output selStrobe_t         strobe
);
  localparam int NT = THREADS;
  localparam int TW = TID_W;

  logic [NT-1:0] elig;
  logic [TW-1:0] rrPtr;
  logic [TW-1:0] pick;
  logic          found;

  assign elig = bufNotEmpty & ~(missStall | trapStall | conflictStall | longOpStall) & ~flush;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NT; k++) begin
      logic [TW-1:0] cand;
      cand = TW'((int'(rrPtr) + k) % NT);
      if (!found && elig[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

  assign strobe.issue = found;
  assign strobe.tid   = pick;

  always_ff @(posedge clk) begin
    if (rst)        rrPtr <= '0;
    else if (found) rrPtr <= TW'((int'(pick) + 1) % NT);
  end

  // R3: the chosen thread has data and no stall source
  a_r3_pick_unstalled: assert property (@(posedge clk) disable iff (rst)
    strobe.issue |-> (bufNotEmpty[strobe.tid] && !missStall[strobe.tid] && !trapStall[strobe.tid]
                      && !conflictStall[strobe.tid] && !longOpStall[strobe.tid] && !flush[strobe.tid]));
  // R4: nothing ready means no pop
  a_r4_idle_no_issue: assert property (@(posedge clk) disable iff (rst)
    (bufNotEmpty == '0) |-> !strobe.issue);
  // R5: pointer moves past the issuer
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    strobe.issue |=> rrPtr == TW'((int'($past(strobe.tid)) + 1) % NT));
  // R5: pointer holds when idle
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.issue |=> $stable(rrPtr));
endmodule

// File: rtl/tsel_datapath.sv
module tsel_datapath
  import tsel_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [THREADS-1:0]         fetchValid,
  input  logic [THREADS-1:0][IW-1:0] fetchData,
  input  logic [THREADS-1:0]         flush,
  input  selStrobe_t                 strobe,
  output logic [THREADS-1:0]         fetchReady,
  output logic [THREADS-1:0]         bufNotEmpty,
  output logic                       issueValid,
  output logic [TID_W-1:0]           issueTid,
  output logic [IW-1:0]              issueInstr
);
  localparam int NT = THREADS;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] headWord [NT];

  for (genvar t = 0; t < NT; t++) begin : g_buf
    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] wrPtr, rdPtr;
    logic [CW-1:0] count;
    logic          push, pop;

    assign fetchReady[t]  = (count != CW'(DEPTH));
    assign bufNotEmpty[t] = (count != '0);
    assign push = fetchValid[t] && fetchReady[t];
    assign pop  = strobe.issue && (strobe.tid == TID_W'(t));
    assign headWord[t] = mem[rdPtr];

    always_ff @(posedge clk) begin
      if (push && !rst && !flush[t]) mem[wrPtr] <= fetchData[t];
    end

    always_ff @(posedge clk) begin
      if (rst || flush[t]) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (push) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (pop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        count <= count + CW'(push) - CW'(pop);
      end
    end

    // R6: occupancy never exceeds the depth
    a_r6_bounded: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH));
    // R6: a full FIFO without pop or flush stays full
    a_r6_refuse_full: assert property (@(posedge clk) disable iff (rst)
      (count == CW'(DEPTH) && !pop && !flush[t]) |=> count == CW'(DEPTH));
    // R8: flush empties the FIFO at the next edge
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
      flush[t] |=> count == '0);
    // R3: never pop an empty FIFO
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
      pop |-> count != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issueValid <= 1'b0;
      issueTid   <= '0;
      issueInstr <= '0;
    end else begin
      issueValid <= strobe.issue;
      issueTid   <= strobe.tid;
      issueInstr <= headWord[strobe.tid];
    end
  end

  // R9: registered outputs follow the pick one edge later
  a_r9_output_follows: assert property (@(posedge clk) disable iff (rst)
    strobe.issue |=> (issueValid && issueTid == $past(strobe.tid)));
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !strobe.issue |=> !issueValid);
endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [THREADS-1:0]         fetchValid,
  input  logic [THREADS-1:0][IW-1:0] fetchData,
  output logic [THREADS-1:0]         fetchReady,
  input  logic [THREADS-1:0]         flush,
  input  logic [THREADS-1:0]         missStall,
  input  logic [THREADS-1:0]         trapStall,
  input  logic [THREADS-1:0]         conflictStall,
  input  logic [THREADS-1:0]         longOpStall,
  output logic                       issueValid,
  output logic [TID_W-1:0]           issueTid,
  output logic [IW-1:0]              issueInstr
);
  selStrobe_t         strobe;
  logic [THREADS-1:0] bufNotEmpty;

  tsel_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .bufNotEmpty   (bufNotEmpty),
    .flush         (flush),
    .missStall     (missStall),
    .trapStall     (trapStall),
    .conflictStall (conflictStall),
    .longOpStall   (longOpStall),
    .strobe        (strobe)
  );

  tsel_datapath #(.DEPTH(DEPTH), .IW(IW)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .fetchValid  (fetchValid),
    .fetchData   (fetchData),
    .flush       (flush),
    .strobe      (strobe),
    .fetchReady  (fetchReady),
    .bufNotEmpty (bufNotEmpty),
    .issueValid  (issueValid),
    .issueTid    (issueTid),
    .issueInstr  (issueInstr)
  );
endmodule

// File: tb/tsel_top_bench.sv
module tsel_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int IW = 32;
  localparam int NROWS = 18;

  // row: miss[18:15] trap[14:11] conflict[10:7] longOp[6:3] expValid[2] expTid[1:0]
  localparam logic [18:0] VEC [NROWS] = '{
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {4'b0100, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3},
    {4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {4'b0000, 4'b0000, 4'b0100, 4'b1000, 1'b1, 2'd0},
    {4'b1111, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b1, 2'd3},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0},
    {4'b0010, 4'b0100, 4'b1000, 4'b0000, 1'b1, 2'd0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0}
  };

  logic                 clk = 1'b0;
  logic                 rst;
  logic [NT-1:0]        fetchValid, fetchReady, flush;
  logic [NT-1:0]        missStall, trapStall, conflictStall, longOpStall;
  logic [NT-1:0][IW-1:0] fetchData;
  logic                 issueValid;
  logic [1:0]           issueTid;
  logic [IW-1:0]        issueInstr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int seqNext [NT];

  tsel_top u_tsel_top (
    .clk(clk), .rst(rst), .fetchValid(fetchValid), .fetchData(fetchData),
    .fetchReady(fetchReady), .flush(flush), .missStall(missStall),
    .trapStall(trapStall), .conflictStall(conflictStall), .longOpStall(longOpStall),
    .issueValid(issueValid), .issueTid(issueTid), .issueInstr(issueInstr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] word(input int tid, input int seq);
    return {8'hC0, 8'(tid), 8'h00, 8'(seq)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic prevV;
    logic [1:0] prevT;
    rst = 1'b1; fetchValid = '0; fetchData = '0; flush = '0;
    missStall = '0; trapStall = '0; conflictStall = '0; longOpStall = '0;
    for (int i = 0; i < NT; i++) seqNext[i] = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(issueValid == 1'b0, "R1 issueValid after reset", 64'(issueValid), 64'd0);
    chk(fetchReady == 4'hF, "R1 fetchReady after reset", 64'(fetchReady), 64'hF);

    // Fill all FIFOs while every thread is held by a miss
    missStall = 4'hF;
    for (int s = 0; s < 4; s++) begin
      fetchValid = 4'hF;
      for (int t = 0; t < NT; t++) fetchData[t] = word(t, s);
      @(negedge clk);
    end
    chk(fetchReady == 4'h0, "R6 fetchReady when full", 64'(fetchReady), 64'h0);
    for (int t = 0; t < NT; t++) fetchData[t] = word(t, 9);
    @(negedge clk);   // refused fifth write
    fetchValid = '0;
    chk(issueValid == 1'b0, "R3 all stalled during fill", 64'(issueValid), 64'd0);

    // Table walk: R2, R3, R4, R5, R6 ordering, R9 timing
    prevV = 1'b0; prevT = '0;
    for (int r = 0; r < NROWS; r++) begin
      missStall     = VEC[r][18:15];
      trapStall     = VEC[r][14:11];
      conflictStall = VEC[r][10:7];
      longOpStall   = VEC[r][6:3];
      #1;
      chk(issueValid == prevV && (!prevV || issueTid == prevT),
          "R9 output holds until edge", {issueValid, issueTid}, {prevV, prevT});
      @(negedge clk);
      chk(issueValid == VEC[r][2], "R4 R3 issueValid per row", 64'(issueValid), 64'(VEC[r][2]));
      if (VEC[r][2]) begin
        chk(issueTid == VEC[r][1:0], "R2 R5 round-robin thread", 64'(issueTid), 64'(VEC[r][1:0]));
        chk(issueInstr == word(int'(VEC[r][1:0]), seqNext[VEC[r][1:0]]),
            "R6 FIFO order", 64'(issueInstr), 64'(word(int'(VEC[r][1:0]), seqNext[VEC[r][1:0]])));
        seqNext[VEC[r][1:0]]++;
      end
      prevV = VEC[r][2]; prevT = VEC[r][1:0];
    end
    missStall = '0; trapStall = '0; conflictStall = '0; longOpStall = '0;

    // R7: write and pop in the same cycle on thread 0
    fetchValid = 4'b0001; fetchData[0] = 32'h1111_0000;
    @(negedge clk);
    chk(issueValid == 1'b0, "R7 no issue before write lands", 64'(issueValid), 64'd0);
    fetchData[0] = 32'h2222_0000;
    @(negedge clk);
    chk(issueValid && issueTid == 2'd0 && issueInstr == 32'h1111_0000,
        "R7 first word with concurrent write", 64'(issueInstr), 64'h1111_0000);
    fetchValid = '0;
    @(negedge clk);
    chk(issueValid && issueInstr == 32'h2222_0000, "R7 word written during pop",
        64'(issueInstr), 64'h2222_0000);
    @(negedge clk);
    chk(issueValid == 1'b0, "R7 FIFO drained", 64'(issueValid), 64'd0);

    // R8: flush overrides a simultaneous write on thread 1
    missStall = 4'b0010; fetchValid = 4'b0010; fetchData[1] = 32'hAAAA_0001;
    @(negedge clk);
    fetchData[1] = 32'hAAAA_0002;
    @(negedge clk);
    flush = 4'b0010; fetchData[1] = 32'hAAAA_0003;
    @(negedge clk);
    flush = '0; fetchValid = '0; missStall = '0;
    @(negedge clk);
    chk(issueValid == 1'b0, "R8 flushed FIFO issues nothing", 64'(issueValid), 64'd0);
    chk(fetchReady == 4'hF, "R8 all FIFOs empty after flush", 64'(fetchReady), 64'hF);

    // R1: mid-run reset clears a FIFO and returns the pointer to thread 0
    missStall = 4'b0100; fetchValid = 4'b0100; fetchData[2] = 32'hBBBB_0000;
    @(negedge clk);
    fetchValid = '0; missStall = '0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(issueValid == 1'b0, "R1 reset emptied FIFO", 64'(issueValid), 64'd0);
    fetchValid = 4'hF;
    for (int t = 0; t < NT; t++) fetchData[t] = word(t, 7);
    @(negedge clk);
    fetchValid = '0;
    @(negedge clk);
    chk(issueValid && issueTid == 2'd0, "R1 pointer reset to thread 0", 64'(issueTid), 64'd0);
    @(negedge clk);
    chk(issueValid && issueTid == 2'd1, "R2 rotation after reset", 64'(issueTid), 64'd1);

    finish_run();
  end
endmodule